// File: doc/BRIEF.md
# Single-Wire Test Packet Router

This block sits on the hub side of a board-level test arrangement in which every device under test is reached through exactly one wire that carries stimulus in one direction and response in the other. A host streams a serial packet into the router one bit per valid strobe. The packet opens with a low-then-high start edge. A fixed header follows, giving the number of stimulus bits, the number of response bits and the index of the target link. The stimulus bits come last.

The router enables the output driver of the addressed link only, and places each stimulus bit on that link as it arrives. When the stimulus count is used up, it releases the wire for one idle cycle. It then listens on the same link for the stated number of response cycles. Each sampled bit goes straight back to the host with a valid strobe, and a one-cycle done pulse follows the last response bit. All other links stay undriven and at zero throughout. Asserting the reset abandons any transfer in progress, so the next packet may go to another link.

Top module: `swire_router`

## Requirements
- R1: A packet starts only when the host delivers a valid 0 and then, on its next valid bit, a 1. A run of valid 1 bits with no preceding 0 starts nothing, and no link output enable rises.
- R2: After the start edge, the next 12 valid host bits form the header, each field most significant bit first. Bits 1 to 4 give the stimulus length. Bits 5 to 8 give the response length. Bits 9 to 12 give the link index, so 4'b1001 selects link 9.
- R3: While stimulus is being sent, `link_oe` equals a one-hot vector with only the selected link's bit set. Every bit of `link_drv` other than the selected link's is 0.
- R4: A stimulus bit accepted from the host on a clock edge appears on the selected `link_drv` bit from that edge until the next stimulus bit is accepted. The last stimulus bit stays driven for one further cycle, after which the drive is removed.
- R5: Between the end of stimulus and the first response cycle there is exactly one cycle in which no `link_oe` bit is set and `host_out_vld` is low.
- R6: The response window lasts exactly as many cycles as the response length. In each of these cycles `host_out_vld` is 1, `host_out_bit` equals the selected link's `link_in` bit and no `link_oe` bit is set.
- R7: `host_done` is high for exactly one cycle, in the cycle after the last response cycle, or in the cycle after the stimulus ends if the response length is 0. `host_out_vld` is low in that cycle.
- R8: A stimulus length of 0 skips the stimulus window, and the turnaround cycle follows the header directly. A response length of 0 skips both the turnaround and the response window. If both lengths are 0, done follows the header directly.
- R9: While `rst_n` is low, all `link_oe`, `link_drv`, `host_out_vld` and `host_done` outputs are 0 and any packet in progress is dropped. After release the router waits for a new start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_in_bit | input | 1 | Serial packet bit from the host |
| host_in_vld | input | 1 | Qualifies host_in_bit for this cycle |
| host_out_bit | output | 1 | Response bit captured from the selected link |
| host_out_vld | output | 1 | Qualifies host_out_bit; high once per response cycle |
| host_done | output | 1 | One-cycle pulse after the packet completes |
| link_drv | output | 16 | Drive value per link |
| link_oe | output | 16 | Output enable per link |
| link_in | input | 16 | Sampled wire value per link |

## Verification
The properties constrain only the router's own outputs: link enables, drive values, the response strobe and the done pulse. So they take nothing for granted about `link_in`, which may hold any pattern. They also accept host bits arriving in any cycle. What they do rely on is that the host does not present a fresh start edge while the router is still busy. Any such bits are dropped, but a bench expecting a second packet would then lose step. The stimulus therefore lowers `host_in_vld` as soon as a packet's stimulus bits are delivered, and only sends the next preamble after the done pulse. While the router listens, the bench drives the selected link with the expected response and every other link with its complement, so a wrong selection shows as an inverted bit.

// File: rtl/swire_pkg.sv
package swire_pkg;

  // Controller phases, in the order a packet visits them
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // waiting for a 0-then-1 start edge
    ST_HDR  = 3'd1,  // collecting length and address fields
    ST_TX   = 3'd2,  // stimulus window, selected link driven
    ST_TURN = 3'd3,  // one released cycle before listening
    ST_RX   = 3'd4,  // response window, selected link sampled
    ST_DONE = 3'd5   // completion pulse
  } swr_state_e;

endpackage

// File: rtl/swire_rst_sync.sv
module swire_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  // Assertion is immediate, release ripples through STAGES flops
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/swire_hdr_shift.sv
module swire_hdr_shift #(
  parameter int HDR_W = 12,
  localparam int CNT_W = $clog2(HDR_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             bit_vld,
  input  logic             bit_in,
  output logic             done,
  output logic [HDR_W-1:0] word
);

  logic [HDR_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             take;

  assign take = en && bit_vld;
  assign done = take && (cnt_q == CNT_W'(HDR_W - 1));
  assign word = {sh_q[HDR_W-2:0], bit_in};

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (!en) begin
      cnt_d = '0;
    end else if (take) begin
      sh_d  = {sh_q[HDR_W-2:0], bit_in};
      cnt_d = done ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/swire_link_demux.sv
module swire_link_demux #(
  parameter int SEL_W = 4,
  localparam int NLINK = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             tx_en,
  input  logic             tx_bit,
  input  logic [NLINK-1:0] link_in,
  output logic [NLINK-1:0] link_drv,
  output logic [NLINK-1:0] link_oe,
  output logic             rx_bit
);

  for (genvar g = 0; g < NLINK; g++) begin : g_link
    logic hit;
    assign hit         = (sel == SEL_W'(g));
    assign link_oe[g]  = tx_en && hit;
    assign link_drv[g] = tx_en && hit && tx_bit;
  end

  assign rx_bit = link_in[sel];

endmodule

// File: rtl/swire_router.sv
module swire_router
  import swire_pkg::*;
#(
  parameter int LEN_W  = 4,
  parameter int ADDR_W = 4,
  localparam int NLINK = 1 << ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_in_bit,
  input  logic             host_in_vld,
  output logic             host_out_bit,
  output logic             host_out_vld,
  output logic             host_done,
  output logic [NLINK-1:0] link_drv,
  output logic [NLINK-1:0] link_oe,
  input  logic [NLINK-1:0] link_in
);

  localparam int HDR_W = 2 * LEN_W + ADDR_W;

  logic              srst_n;
  swr_state_e        state_q, state_d;
  logic              prev_q, prev_d;
  logic [LEN_W-1:0]  rlen_q, rlen_d;
  logic [ADDR_W-1:0] sel_q, sel_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic              txb_q, txb_d;

  logic              hdr_done;
  logic [HDR_W-1:0]  hdr_word;
  logic [LEN_W-1:0]  f_tlen, f_rlen;
  logic [ADDR_W-1:0] f_addr;
  logic              rx_bit;
  logic              in_tx, in_rx;

  swire_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  swire_hdr_shift #(.HDR_W(HDR_W)) u_hdr (
    .clk     (clk),
    .rst_n   (srst_n),
    .en      (state_q == ST_HDR),
    .bit_vld (host_in_vld),
    .bit_in  (host_in_bit),
    .done    (hdr_done),
    .word    (hdr_word)
  );

  // Field order on the wire: stimulus length, response length, address
  assign f_tlen = hdr_word[HDR_W-1 -: LEN_W];
  assign f_rlen = hdr_word[ADDR_W+LEN_W-1 -: LEN_W];
  assign f_addr = hdr_word[ADDR_W-1:0];

  assign in_tx = (state_q == ST_TX);
  assign in_rx = (state_q == ST_RX);

  swire_link_demux #(.SEL_W(ADDR_W)) u_demux (
    .sel      (sel_q),
    .tx_en    (in_tx),
    .tx_bit   (txb_q),
    .link_in  (link_in),
    .link_drv (link_drv),
    .link_oe  (link_oe),
    .rx_bit   (rx_bit)
  );

  assign host_out_vld = in_rx;
  assign host_out_bit = in_rx && rx_bit;
  assign host_done    = (state_q == ST_DONE);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    prev_d  = prev_q;
    rlen_d  = rlen_q;
    sel_d   = sel_q;
    cnt_d   = cnt_q;
    txb_d   = txb_q;
    unique case (state_q)
      ST_IDLE: begin
        if (host_in_vld) begin
          prev_d = host_in_bit;
          if (!prev_q && host_in_bit) state_d = ST_HDR;
        end
      end
      ST_HDR: begin
        if (hdr_done) begin
          rlen_d = f_rlen;
          sel_d  = f_addr;
          cnt_d  = f_tlen;
          txb_d  = 1'b0;
          if (f_tlen != '0)      state_d = ST_TX;
          else if (f_rlen != '0) state_d = ST_TURN;
          else                   state_d = ST_DONE;
        end
      end
      ST_TX: begin
        if (cnt_q == '0) begin
          state_d = (rlen_q != '0) ? ST_TURN : ST_DONE;
        end else if (host_in_vld) begin
          txb_d = host_in_bit;
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_TURN: begin
        cnt_d   = rlen_q;
        state_d = ST_RX;
      end
      ST_RX: begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == LEN_W'(1)) state_d = ST_DONE;
      end
      ST_DONE: begin
        prev_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      prev_q  <= 1'b1;
      rlen_q  <= '0;
      sel_q   <= '0;
      cnt_q   <= '0;
      txb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      prev_q  <= prev_d;
      rlen_q  <= rlen_d;
      sel_q   <= sel_d;
      cnt_q   <= cnt_d;
      txb_q   <= txb_d;
    end
  end

endmodule

// File: rtl/swire_router_chk.sv
module swire_router_chk #(
  parameter int NLINK = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NLINK-1:0] link_oe,
  input logic [NLINK-1:0] link_drv,
  input logic             host_out_vld,
  input logic             host_done
);

  // R3
  oe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(link_oe));

  // R3
  drv_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_drv & ~link_oe) == '0);

  // R4
  oe_sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|link_oe) && $past(|link_oe)) |-> (link_oe == $past(link_oe)));

  // R5
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(|link_oe) |-> !host_out_vld);

  // R6
  rx_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_out_vld |-> (link_oe == '0));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |-> (!host_out_vld && (link_oe == '0)));

endmodule

bind swire_router swire_router_chk #(.NLINK(NLINK)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .link_oe      (link_oe),
  .link_drv     (link_drv),
  .host_out_vld (host_out_vld),
  .host_done    (host_done)
);

// File: tb/swire_router_bench.sv
module swire_router_bench;

  localparam int NL = 16;

  logic          clk;
  logic          rst_n;
  logic          hin_bit, hin_vld;
  logic          hout_bit, hout_vld, hdone;
  logic [NL-1:0] link_drv, link_oe, link_in;

  int n_run;
  int n_fail;

  swire_router u_swire_router (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_in_bit  (hin_bit),
    .host_in_vld  (hin_vld),
    .host_out_bit (hout_bit),
    .host_out_vld (hout_vld),
    .host_done    (hdone),
    .link_drv     (link_drv),
    .link_oe      (link_oe),
    .link_in      (link_in)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic pay_bit(input int ad, input int i);
    return logic'(((ad * 11 + i * 5 + 3) >> 2) & 1);
  endfunction

  function automatic logic rsp_bit(input int ad, input int j);
    return logic'((((ad * 13 + j * 7) >> 1) ^ j) & 1);
  endfunction

  task automatic send(input logic b);
    @(negedge clk);
    hin_vld = 1'b1;
    hin_bit = b;
  endtask

  task automatic send_hdr(input int tl, input int rl, input int ad);
    send(1'b0);
    send(1'b1);
    for (int k = 3; k >= 0; k--) send(logic'((tl >> k) & 1));
    for (int k = 3; k >= 0; k--) send(logic'((rl >> k) & 1));
    for (int k = 3; k >= 0; k--) send(logic'((ad >> k) & 1));
  endtask

  task automatic run_packet(input int tl, input int rl, input int ad);
    logic [NL-1:0] one;
    one = NL'(1) << ad;
    send_hdr(tl, rl, ad);
    for (int i = 0; i < tl; i++) begin
      @(negedge clk);
      chk("R3 oe one-hot on selected link", 32'(link_oe), 32'(one));
      if (i == 0) chk("R4 drive cleared at window start", 32'(link_drv), 32'h0);
      else        chk("R4 stimulus bit on link", 32'(link_drv), pay_bit(ad, i - 1) ? 32'(one) : 32'h0);
      hin_vld = 1'b1;
      hin_bit = pay_bit(ad, i);
    end
    @(negedge clk);
    hin_vld = 1'b0;
    if (tl > 0) begin
      chk("R4 last stimulus bit held", 32'(link_drv), pay_bit(ad, tl - 1) ? 32'(one) : 32'h0);
      chk("R3 oe held for last bit", 32'(link_oe), 32'(one));
      @(negedge clk);
    end
    if (rl > 0) begin
      chk("R5 turnaround no enable", 32'(link_oe), 32'h0);
      chk("R5 turnaround no valid", 32'(hout_vld), 32'h0);
      chk("R8 no done before response", 32'(hdone), 32'h0);
      for (int j = 0; j < rl; j++) begin
        @(negedge clk);
        link_in = rsp_bit(ad, j) ? one : ~one;
        #1;
        chk("R6 response valid", 32'(hout_vld), 32'h1);
        chk("R6 response bit from selected link", 32'(hout_bit), 32'(rsp_bit(ad, j)));
        chk("R6 link released while listening", 32'(link_oe), 32'h0);
      end
      @(negedge clk);
    end
    chk("R7 done pulse", 32'(hdone), 32'h1);
    chk("R7 no valid with done", 32'(hout_vld), 32'h0);
    @(negedge clk);
    chk("R7 done lasts one cycle", 32'(hdone), 32'h0);
    chk("R8 window closed", 32'(link_oe), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run   = 0;
    n_fail  = 0;
    rst_n   = 1'b0;
    hin_bit = 1'b0;
    hin_vld = 1'b0;
    link_in = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset enables off", 32'(link_oe), 32'h0);
    chk("R9 reset no valid", 32'(hout_vld), 32'h0);
    chk("R9 reset no done", 32'(hdone), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: ones alone never start a packet
    for (int i = 0; i < 20; i++) begin
      send(1'b1);
      chk("R1 no start on ones", 32'(link_oe | NL'(hout_vld)), 32'h0);
    end
    @(negedge clk);
    hin_vld = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R1 still idle", 32'(link_oe), 32'h0);
    end

    // R2: address 4'b1001 reaches link 9
    run_packet(7, 5, 9);

    // R2/R3/R6: sweep every link with varied lengths, including zeros (R8)
    for (int a = 0; a < NL; a++) run_packet((a * 5) % 16, (a * 7 + 2) % 16, a);
    run_packet(0, 0, 5);
    run_packet(15, 15, 15);
    run_packet(1, 1, 0);

    // R9: reset in the middle of a stimulus window
    send_hdr(10, 3, 3);
    for (int i = 0; i < 4; i++) send(pay_bit(3, i));
    @(negedge clk);
    hin_vld = 1'b0;
    chk("R9 window open before abort", 32'(link_oe), 32'(NL'(1) << 3));
    rst_n = 1'b0;
    #1;
    chk("R9 abort drops enable", 32'(link_oe), 32'h0);
    chk("R9 abort drops drive", 32'(link_drv), 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 idle after abort", 32'(link_oe), 32'h0);
    run_packet(5, 4, 9);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule